// File: doc/BRIEF.md
# Character Edge Outline Generator

This block sits in the per-dot path of a character-cell display. For each dot it takes three glyph bits: the dot on the current scan line and the dots directly above and below it in the same cell region. From these it produces a foreground flag and an edge flag. Downstream colour logic forces a dot to black when the edge flag is high. This keeps glyphs readable over backgrounds of a similar colour. Glyph cells are 10 dots wide and 16 lines tall, and adjacent cells touch with no gap. A correct outline therefore relies on every glyph keeping at least one blank dot on each side inside its cell.

Two styles are offered. A border surrounds the glyph on all four sides. A shadow adds a one-dot dark edge only to the right of and below the glyph strokes. An enable input switches the feature off, and the glyph dots then pass through unchanged. The dot stream enters and leaves through valid/ready handshakes. Each beat carries `LANES` adjacent dots, with lane 0 the leftmost. A line-start flag on the first beat of each scan line stops neighbourhoods from reaching across line ends.

Back-pressure rules are as follows. A beat transfers on a clock edge where valid and ready are both high. The output holds its data while `out_valid` is high and `out_ready` is low. `in_ready` is high exactly when the output register is empty or is being drained in the same cycle. A dot's result is released only after the beat to its right has been accepted, because the right-hand neighbour is needed first.

Top module: `osd_edge_gen`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `out_fg` of a dot equals that dot's `in_mid` bit, whatever the enable and style settings.
- R3: With `edge_en`=1 and `edge_style`=0 (border), `out_edge` is 1 when the dot's `in_mid` is 0 and any of its eight neighbours is a glyph dot. The eight neighbours are left, right, up and down, and the four diagonals.
- R4: With `edge_en`=1 and `edge_style`=1 (shadow), `out_edge` is 1 only when the dot's `in_mid` is 0 and at least one of three neighbours is a glyph dot: the left dot, the dot above, or the dot above-left. Glyph dots at right, below-left, below, above-right or below-right produce no edge.
- R5: With `edge_en`=0, `out_edge` is 0 for every dot, and `out_fg` follows R2.
- R6: A glyph dot never has `out_edge`=1 (the foreground wins).
- R7: Under continuous flow, the result for a beat is valid two clocks after that beat is presented. No result for a beat appears before the next beat has been accepted.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, and `out_valid`, `out_fg` and `out_edge` stay unchanged. Each result transfers exactly once.
- R9: A beat with `in_sol`=1 starts a new scan line. The last dot of the previous line and the first dot of the new line do not count as each other's neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_en | input | 1 | 1 enables edge generation |
| edge_style | input | 1 | 0 selects border, 1 selects shadow |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with `in_valid` |
| in_sol | input | 1 | Beat is the first of a scan line |
| in_up | input | LANES | Glyph dots on the line above |
| in_mid | input | LANES | Glyph dots on the current line |
| in_dn | input | LANES | Glyph dots on the line below |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Downstream takes the result |
| out_fg | output | LANES | Foreground flag per dot |
| out_edge | output | LANES | Force-to-black edge flag per dot |

## Verification
Two events that share a cycle get the most attention. In one, a line-start beat is accepted while the edge of the previous line's last dot is being evaluated. The bench places glyph dots on both sides of line boundaries and expects no edge on the dots next to each boundary. In the other, downstream stalls while an upstream beat is waiting. The bench holds `out_ready` low with a beat presented and checks that `in_ready` drops and the held result does not move. On release, the pending result, the stalled beat and its edge computed against the previous dot each appear exactly once.

// File: rtl/osd_edge_pkg.sv
package osd_edge_pkg;
  typedef struct packed {
    logic up;
    logic mid;
    logic dn;
  } dot_col_t;

  localparam dot_col_t BLANK_COL = '0;

  typedef enum logic {
    STYLE_BORDER = 1'b0,
    STYLE_SHADOW = 1'b1
  } edge_style_e;
endpackage

// File: rtl/osd_edge_window.sv
module osd_edge_window
  import osd_edge_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift,
  input  logic                  in_sol,
  input  dot_col_t [LANES-1:0]  in_cols,
  output dot_col_t [LANES-1:0]  cur_cols,
  output logic                  cur_vld,
  output dot_col_t              left_col,
  output dot_col_t              right_col
);
  localparam int LAST = LANES - 1;

  dot_col_t [LANES-1:0] cur_q;
  dot_col_t             prev_last_q;
  logic                 cur_sol_q;
  logic                 cur_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q       <= '0;
      prev_last_q <= BLANK_COL;
      cur_sol_q   <= 1'b0;
      cur_vld_q   <= 1'b0;
    end else if (shift) begin
      prev_last_q <= cur_q[LAST];
      cur_q       <= in_cols;
      cur_sol_q   <= in_sol;
      cur_vld_q   <= 1'b1;
    end
  end

  // Neighbours across a line start are treated as blank (R9).
  assign left_col  = cur_sol_q ? BLANK_COL : prev_last_q;
  assign right_col = in_sol    ? BLANK_COL : in_cols[0];
  assign cur_cols  = cur_q;
  assign cur_vld   = cur_vld_q;
endmodule

// File: rtl/osd_edge_detect.sv
module osd_edge_detect
  import osd_edge_pkg::*;
(
  input  dot_col_t    left_col,
  input  dot_col_t    ctr_col,
  input  dot_col_t    right_col,
  input  logic        en,
  input  edge_style_e style,
  output logic        fg,
  output logic        rim
);
  logic ring_hit;
  logic trail_hit;

  always_comb begin
    ring_hit  = left_col.up | left_col.mid | left_col.dn |
                ctr_col.up  | ctr_col.dn   |
                right_col.up | right_col.mid | right_col.dn;
    trail_hit = left_col.mid | left_col.up | ctr_col.up;
    fg        = ctr_col.mid;
    rim       = en & ~ctr_col.mid &
                ((style == STYLE_SHADOW) ? trail_hit : ring_hit);
  end
endmodule

// File: rtl/osd_edge_outreg.sv
module osd_edge_outreg #(
  parameter int LANES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_fire,
  input  logic             load_vld,
  input  logic [LANES-1:0] fg_d,
  input  logic [LANES-1:0] rim_d,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [LANES-1:0] out_fg,
  output logic [LANES-1:0] out_rim,
  output logic             can_take
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fg    <= '0;
      out_rim   <= '0;
    end else if (in_fire) begin
      out_valid <= load_vld;
      out_fg    <= fg_d;
      out_rim   <= rim_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign can_take = !out_valid || out_ready;

  assert_hold_when_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_fg) && $stable(out_rim)));

  assert_no_take_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !can_take);

  assert_no_early_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !load_vld) |=> !out_valid);
endmodule

// File: rtl/osd_edge_gen.sv
module osd_edge_gen
  import osd_edge_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_en,
  input  logic             edge_style,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sol,
  input  logic [LANES-1:0] in_up,
  input  logic [LANES-1:0] in_mid,
  input  logic [LANES-1:0] in_dn,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LANES-1:0] out_fg,
  output logic [LANES-1:0] out_edge
);
  localparam int LAST = LANES - 1;

  dot_col_t [LANES-1:0] in_cols;
  dot_col_t [LANES-1:0] cur_cols;
  dot_col_t             left_col;
  dot_col_t             right_col;
  logic                 cur_vld;
  logic                 in_fire;
  logic [LANES-1:0]     fg_d;
  logic [LANES-1:0]     rim_d;
  logic [LANES-1:0]     cur_mid;
  edge_style_e          style;

  assign style   = edge_style_e'(edge_style);
  assign in_fire = in_valid && in_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_pack
    assign in_cols[i].up  = in_up[i];
    assign in_cols[i].mid = in_mid[i];
    assign in_cols[i].dn  = in_dn[i];
    assign cur_mid[i]     = cur_cols[i].mid;
  end

  osd_edge_window #(.LANES(LANES)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift     (in_fire),
    .in_sol    (in_sol),
    .in_cols   (in_cols),
    .cur_cols  (cur_cols),
    .cur_vld   (cur_vld),
    .left_col  (left_col),
    .right_col (right_col)
  );

  // Lane 0 is leftmost; outer lanes borrow neighbours from adjacent beats.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    dot_col_t lnb;
    dot_col_t rnb;
    if (i == 0) begin : g_lft_edge
      assign lnb = left_col;
    end else begin : g_lft_in
      assign lnb = cur_cols[i-1];
    end
    if (i == LAST) begin : g_rgt_edge
      assign rnb = right_col;
    end else begin : g_rgt_in
      assign rnb = cur_cols[i+1];
    end
    osd_edge_detect u_det (
      .left_col  (lnb),
      .ctr_col   (cur_cols[i]),
      .right_col (rnb),
      .en        (edge_en),
      .style     (style),
      .fg        (fg_d[i]),
      .rim       (rim_d[i])
    );
  end

  osd_edge_outreg #(.LANES(LANES)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_fire   (in_fire),
    .load_vld  (cur_vld),
    .fg_d      (fg_d),
    .rim_d     (rim_d),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_fg    (out_fg),
    .out_rim   (out_edge),
    .can_take  (in_ready)
  );

  assert_edge_off_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !edge_en) |=> (out_edge == '0));

  assert_fg_tracks_centre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && cur_vld) |=> (out_fg == $past(cur_mid)));

  assert_fg_over_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_fg & out_edge) == '0));
endmodule

// File: tb/sim_osd_edge_gen.sv
module sim_osd_edge_gen;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 1;
  localparam int NVEC = 16;
  // {en, style, nb[8:0], exp_fg, exp_edge}
  // nb: 8 up-left, 7 up, 6 up-right, 5 left, 4 centre, 3 right, 2 dn-left, 1 dn, 0 dn-right
  localparam logic [12:0] VEC [NVEC] = '{
    13'b1_0_000000000_0_0,
    13'b1_0_000010000_1_0,
    13'b1_0_000001000_0_1,
    13'b1_0_000000001_0_1,
    13'b1_0_100000000_0_1,
    13'b1_1_000001000_0_0,
    13'b1_1_000000010_0_0,
    13'b1_1_000100000_0_1,
    13'b1_1_010000000_0_1,
    13'b1_1_100000000_0_1,
    13'b1_1_001000000_0_0,
    13'b0_0_111101111_0_0,
    13'b0_0_111111111_1_0,
    13'b1_0_111111111_1_0,
    13'b1_1_000000100_0_0,
    13'b1_0_000000010_0_1
  };

  logic clk = 1'b0;
  logic rst_n, edge_en, edge_style, in_valid, in_ready, in_sol, out_valid, out_ready;
  logic [LANES-1:0] in_up, in_mid, in_dn, out_fg, out_edge;

  int n_chk = 0;
  int n_fail = 0;
  int rec_n = 0;
  logic rec_fg [0:1023];
  logic rec_edge [0:1023];
  logic cand_v = 1'b0;
  logic cand_fg, cand_edge;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_edge_gen #(.LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .edge_en(edge_en), .edge_style(edge_style),
    .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol),
    .in_up(in_up), .in_mid(in_mid), .in_dn(in_dn),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_fg(out_fg), .out_edge(out_edge)
  );

  // Records each output transfer once; sampled mid-cycle.
  always @(negedge clk) begin
    if (cand_v === 1'b1) begin
      rec_fg[rec_n]   = cand_fg;
      rec_edge[rec_n] = cand_edge;
      rec_n++;
    end
    #2;
    cand_v    = out_valid & out_ready;
    cand_fg   = out_fg[0];
    cand_edge = out_edge[0];
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic send(input logic sol, input logic u, input logic m, input logic d);
    in_valid  = 1'b1;
    in_sol    = sol;
    in_up[0]  = u;
    in_mid[0] = m;
    in_dn[0]  = d;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    #3;
  endtask

  function automatic string vec_tag(input logic en, input logic st);
    if (!en) return "R5";
    if (st) return "R4";
    return "R3";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    logic hold_fg, hold_edge;
    rst_n = 1'b0; edge_en = 1'b1; edge_style = 1'b0; in_valid = 1'b0;
    in_sol = 1'b0; in_up = '0; in_mid = '0; in_dn = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "out_valid after reset", out_valid, 1'b0);
    chk("R1", "in_ready after reset", in_ready, 1'b1);
    @(negedge clk);

    // R7: first beat alone yields nothing; second beat releases it.
    send(1'b1, 1'b0, 1'b1, 1'b0);
    chk("R7", "no result after one beat", out_valid, 1'b0);
    send(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7", "result after second beat", out_valid, 1'b1);
    chk("R2", "latency fg", out_fg[0], 1'b1);
    chk("R6", "latency glyph edge", out_edge[0], 1'b0);
    settle();

    // Table: one 3x3 neighbourhood per vector, centre result checked.
    base = rec_n;
    for (int k = 0; k < NVEC; k++) begin
      logic [8:0] nb;
      nb = VEC[k][10:2];
      edge_en    = VEC[k][12];
      edge_style = VEC[k][11];
      send(1'b1, nb[8], nb[5], nb[2]);
      send(1'b0, nb[7], nb[4], nb[1]);
      send(1'b0, nb[6], nb[3], nb[0]);
      send(1'b1, 1'b0, 1'b0, 1'b0);
    end
    settle();
    for (int k = 0; k < NVEC; k++) begin
      int idx;
      idx = base + 2 + 4 * k;
      chk("R2", $sformatf("vector %0d fg", k), rec_fg[idx], VEC[k][1]);
      chk(vec_tag(VEC[k][12], VEC[k][11]), $sformatf("vector %0d edge (R6 on glyphs)", k),
          rec_edge[idx], VEC[k][0]);
    end

    // R8: back-pressure while a beat waits.
    edge_en = 1'b1; edge_style = 1'b0;
    base = rec_n;
    out_ready = 1'b0;
    send(1'b1, 1'b0, 1'b1, 1'b0);
    in_valid = 1'b1; in_sol = 1'b0; in_up = '0; in_mid = '0; in_dn = '0;
    #1;
    chk("R8", "in_ready during stall", in_ready, 1'b0);
    hold_fg = out_fg[0];
    hold_edge = out_edge[0];
    repeat (3) @(negedge clk);
    #1;
    chk("R8", "valid held", out_valid, 1'b1);
    chk("R8", "fg held", out_fg[0], hold_fg);
    chk("R8", "edge held", out_edge[0], hold_edge);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    send(1'b1, 1'b0, 1'b0, 1'b0);
    settle();
    chk("R8", "transfer count", (rec_n - base) == 3, 1'b1);
    chk("R8", "stalled glyph fg", rec_fg[base+1], 1'b1);
    chk("R8", "beat after stall fg", rec_fg[base+2], 1'b0);
    chk("R3", "beat after stall edge", rec_edge[base+2], 1'b1);

    // R9: glyphs adjacent across line starts must not outline each other.
    base = rec_n;
    send(1'b1, 1'b0, 1'b0, 1'b0);
    send(1'b0, 1'b0, 1'b0, 1'b0);
    send(1'b1, 1'b0, 1'b1, 1'b0);
    send(1'b0, 1'b0, 1'b1, 1'b0);
    send(1'b1, 1'b0, 1'b0, 1'b0);
    send(1'b0, 1'b0, 1'b0, 1'b0);
    send(1'b1, 1'b0, 1'b0, 1'b0);
    settle();
    chk("R9", "line end before glyph line", rec_edge[base+2], 1'b0);
    chk("R2", "glyph line first dot", rec_fg[base+3], 1'b1);
    chk("R9", "line start after glyph line", rec_edge[base+5], 1'b0);
    chk("R3", "interior blank dot", rec_edge[base+6], 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule